// File: doc/BRIEF.md
# Wake Pin Event Detector

This block monitors a small set of asynchronous wake pins and turns each one into an event bit, using a trigger condition that software picks separately for every pin. Each pin first passes through a two-stage synchroniser. A per-pin detector then compares the synchronised level with the level of the previous cycle. From that comparison it produces either a level-qualified event or a single-cycle edge event. The event vector feeds a separate status and interrupt block, which is not part of this design.

Software reaches each pin through one 32-bit word on a simple memory-mapped bus with a combinational read path. The word shows the pin's live synchronised level. It holds the pin's three-bit trigger code. It also has a write-only strobe that wipes the detector's edge history. Every pin comes out of reset in the disabled code, so nothing is reported until software selects a trigger.

Top module: `wake_pin_detect`

## Requirements
- R1: Pin n's word is at byte address 0x330 + 8*n. A read of any other address returns zero, and a write to any other address changes no pin's state.
- R2: Bit 0 of a pin's word returns the pin level after two clock edges of synchronisation. A level driven before edge k is visible after edge k+1.
- R3: Bits [3:1] store the trigger code as written and read it back. The code after reset is 4.
- R4: Writing 1 to bit 4 zeroes that pin's stored previous level in the same clock edge. Bit 4 and bits [31:5] always read as 0.
- R5: Bit 0 is read-only. Writing it has no effect on the readback or on events.
- R6: Code 0 (level low) asserts the event on every cycle in which the synchronised level is 0.
- R7: Code 1 (level high) asserts the event on every cycle in which the synchronised level is 1.
- R8: Code 2 (falling) asserts the event for exactly one cycle when the synchronised level goes from 1 to 0.
- R9: Code 3 (rising) asserts the event for exactly one cycle when the synchronised level goes from 0 to 1.
- R10: Code 6 (either edge) asserts the event for one cycle on every change of the synchronised level.
- R11: Codes 4, 5 and 7 never assert the event.
- R12: The code and pin of one index have no effect on the event of any other index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wake_pin_i | input | NUM_PINS | Asynchronous wake pin levels |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational, zero when not selected |
| wake_evt_o | output | NUM_PINS | Per-pin event bits |

## Verification
The hardest case to reach is the history-clear strobe acting on a pin that is already high in rising mode. The only visible effect is a one-cycle rising event with no pin activity at all. The bench holds a pin high until the history has settled, then writes the same rising code with bit 4 set. It expects exactly one event cycle right after the write edge. Every code from 0 to 7, including the two unused ones, is swept on every pin through a full low-high-low excursion. At each cycle the expected event is computed from the current and previous synchronised levels.

// File: rtl/wake_pin_pkg.sv
package wake_pin_pkg;

    localparam int unsigned MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        TRIG_LOW  = 3'd0,
        TRIG_HIGH = 3'd1,
        TRIG_FALL = 3'd2,
        TRIG_RISE = 3'd3,
        TRIG_OFF  = 3'd4,
        TRIG_RSV5 = 3'd5,
        TRIG_ANY  = 3'd6,
        TRIG_RSV7 = 3'd7
    } trig_mode_e;

    // bit positions inside a pin word
    localparam int unsigned LVL_BIT  = 0;
    localparam int unsigned MODE_LSB = 1;
    localparam int unsigned MODE_MSB = 3;
    localparam int unsigned CLR_BIT  = 4;

    function automatic logic mode_is_off(input logic [MODE_W-1:0] m);
        return (m == TRIG_OFF) || (m == TRIG_RSV5) || (m == TRIG_RSV7);
    endfunction

endpackage

// File: rtl/wake_pin_sync.sv
module wake_pin_sync #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] lvl_o
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] lvl;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = async_i;
        st_d.lvl  = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o = st_q.lvl;

    // cycles since reset, for the latency check below
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            warm_q <= 2'd0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    // R2
    sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (lvl_o == $past(async_i, 2)));

endmodule

// File: rtl/wake_pin_edge.sv
module wake_pin_edge
    import wake_pin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              hist_clr_i,
    output logic              evt_o
);

    typedef struct packed {
        logic prev;
    } hist_t;

    hist_t h_d, h_q;
    logic  rise, fall;

    always_comb begin
        h_d      = h_q;
        h_d.prev = hist_clr_i ? 1'b0 : lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign rise = lvl_i & ~h_q.prev;
    assign fall = ~lvl_i & h_q.prev;

    always_comb begin
        unique case (mode_i)
            TRIG_LOW:  evt_o = ~lvl_i;
            TRIG_HIGH: evt_o = lvl_i;
            TRIG_FALL: evt_o = fall;
            TRIG_RISE: evt_o = rise;
            TRIG_ANY:  evt_o = rise | fall;
            default:   evt_o = 1'b0;
        endcase
    end

    // R11
    off_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_is_off(mode_i) |-> !evt_o);

    // R7
    level_high_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == TRIG_HIGH) |-> (evt_o == lvl_i));

    // R6
    level_low_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == TRIG_LOW) |-> (evt_o == !lvl_i));

    // R9
    rise_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i == TRIG_RISE) && evt_o) |-> lvl_i);

endmodule

// File: rtl/wake_pin_cfg.sv
module wake_pin_cfg
    import wake_pin_pkg::*;
#(
    parameter int unsigned NUM_PINS  = 4,
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned BASE_ADDR = 'h330,
    parameter int unsigned STRIDE    = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           sel_i,
    input  logic                           wr_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [DATA_W-1:0]              wdata_i,
    input  logic [NUM_PINS-1:0]            lvl_i,
    output logic [NUM_PINS-1:0][MODE_W-1:0] mode_o,
    output logic [NUM_PINS-1:0]            hist_clr_o,
    output logic [DATA_W-1:0]              rdata_o
);

    typedef struct packed {
        logic [NUM_PINS-1:0][MODE_W-1:0] mode;
    } cfg_t;

    cfg_t                c_d, c_q;
    logic [NUM_PINS-1:0] hit;
    logic                unused_wbits;

    assign unused_wbits = ^{wdata_i[DATA_W-1:CLR_BIT+1], wdata_i[LVL_BIT]};

    always_comb begin
        for (int n = 0; n < NUM_PINS; n++) begin
            hit[n] = (addr_i == ADDR_W'(BASE_ADDR + STRIDE * n));
        end
    end

    always_comb begin
        c_d        = c_q;
        hist_clr_o = '0;
        rdata_o    = '0;
        for (int n = 0; n < NUM_PINS; n++) begin
            if (sel_i && hit[n]) begin
                if (wr_i) begin
                    c_d.mode[n]   = wdata_i[MODE_MSB:MODE_LSB];
                    hist_clr_o[n] = wdata_i[CLR_BIT];
                end else begin
                    rdata_o[LVL_BIT]           = lvl_i[n];
                    rdata_o[MODE_MSB:MODE_LSB] = c_q.mode[n];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int n = 0; n < NUM_PINS; n++) c_q.mode[n] <= TRIG_OFF;
        end else begin
            c_q <= c_d;
        end
    end

    assign mode_o = c_q.mode;

    // R1
    one_word_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    // R4
    strobe_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_o[DATA_W-1:CLR_BIT] == '0);

    // R1
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |-> (rdata_o == '0));

endmodule

// File: rtl/wake_pin_detect.sv
module wake_pin_detect
    import wake_pin_pkg::*;
#(
    parameter int unsigned NUM_PINS  = 4,
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned BASE_ADDR = 'h330,
    parameter int unsigned STRIDE    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] wake_pin_i,
    input  logic                bus_sel_i,
    input  logic                bus_wr_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [31:0]         bus_wdata_i,
    output logic [31:0]         bus_rdata_o,
    output logic [NUM_PINS-1:0] wake_evt_o
);

    localparam int unsigned DATA_W = 32;

    logic [NUM_PINS-1:0]             lvl;
    logic [NUM_PINS-1:0][MODE_W-1:0] mode;
    logic [NUM_PINS-1:0]             hist_clr;

    wake_pin_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (wake_pin_i),
        .lvl_o   (lvl)
    );

    wake_pin_cfg #(
        .NUM_PINS  (NUM_PINS),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .BASE_ADDR (BASE_ADDR),
        .STRIDE    (STRIDE)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (bus_sel_i),
        .wr_i       (bus_wr_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .lvl_i      (lvl),
        .mode_o     (mode),
        .hist_clr_o (hist_clr),
        .rdata_o    (bus_rdata_o)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        wake_pin_edge u_edge (
            .clk        (clk),
            .rst_n      (rst_n),
            .lvl_i      (lvl[g]),
            .mode_i     (mode[g]),
            .hist_clr_i (hist_clr[g]),
            .evt_o      (wake_evt_o[g])
        );
    end

endmodule

// File: tb/wake_pin_detect_bench.sv
module wake_pin_detect_bench;

    localparam int NP   = 4;
    localparam int BASE = 'h330;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NP-1:0] pin = '0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NP-1:0] evt;

    int vectors = 0, errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wake_pin_detect u_wake_pin_detect (
        .clk(clk), .rst_n(rst_n), .wake_pin_i(pin),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .wake_evt_o(evt)
    );

    function automatic logic exp_evt(int m, logic l, logic p);
        case (m)
            0: return !l;
            1: return l;
            2: return !l && p;
            3: return l && !p;
            6: return l != p;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_word(int a, logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = 12'(a); wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic rd_word(int a, output logic [31:0] d);
        sel = 1'b1; wr = 1'b0; addr = 12'(a);
        #1 d = rdata;
        sel = 1'b0;
    endtask

    function automatic logic [31:0] word(int m, logic l);
        return {28'b0, 3'(m), l};
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 reset code 4 on every pin, R11 no events
        for (int p = 0; p < NP; p++) begin
            rd_word(BASE + 8 * p, r);
            chk("R3 reset word", r, word(4, 1'b0));
        end
        chk("R11 reset events", 32'(evt), 32'd0);

        // R1 unmapped reads and writes
        rd_word(BASE + 4, r);  chk("R1 gap read", r, 0);
        rd_word(BASE - 8, r);  chk("R1 below read", r, 0);
        wr_word(BASE + 4, 32'h6);
        rd_word(BASE, r);      chk("R1 gap write", r, word(4, 1'b0));

        // R5 bit 0 write ignored, R4 strobe reads zero
        wr_word(BASE + 8, 32'h1F);
        rd_word(BASE + 8, r);  chk("R5 R4 readback", r, word(7, 1'b0));
        chk("R5 no event", 32'(evt), 32'd0);

        // R4 history clear while pin held high in rising mode
        wr_word(BASE + 16, word(3, 1'b0));
        pin[2] = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9 settled high quiet", 32'(evt), 32'd0);
        wr_word(BASE + 16, 32'h16);
        chk("R4 clear rising pulse", 32'(evt), 32'h4);
        @(negedge clk);
        chk("R4 pulse one cycle", 32'(evt), 32'd0);
        pin[2] = 1'b0;
        repeat (3) @(negedge clk);

        // sweep every code on every pin; other pins in rising mode stay low
        for (int p = 0; p < NP; p++) begin
            for (int m = 0; m < 8; m++) begin
                logic l, pv, l_n;
                pin = '0;
                for (int q = 0; q < NP; q++)
                    wr_word(BASE + 8 * q, (q == p) ? word(m, 1'b0) : word(3, 1'b0));
                repeat (2) @(negedge clk);
                l = 1'b0; pv = 1'b0;
                // R6 R7 R8 R9 R10 R11 R12 checked through one excursion
                for (int c = 0; c < 6; c++) begin
                    logic drive;
                    drive = (c < 3) ? 1'b1 : 1'b0;
                    if (c == 0 || c == 3) pin[p] = drive;
                    @(negedge clk);
                    // level visible after two edges from the drive
                    l_n = (c == 0 || c == 3) ? l : ((c < 3) ? 1'b1 : 1'b0);
                    pv = l; l = l_n;
                    chk($sformatf("R6-10/R11/R12 pin%0d code%0d cyc%0d", p, m, c),
                        32'(evt), 32'(exp_evt(m, l, pv)) << p);
                end
                rd_word(BASE + 8 * p, r);
                chk("R2 R3 sweep readback", r, word(m, 1'b0));
            end
        end

        // R2 level readback timing
        wr_word(BASE, word(4, 1'b0));
        pin[0] = 1'b1;
        @(negedge clk);
        rd_word(BASE, r); chk("R2 one edge", r, word(4, 1'b0));
        @(negedge clk);
        rd_word(BASE, r); chk("R2 two edges", r, word(4, 1'b1));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule